// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block is a real-time-clock peripheral on a byte-wide register bus. It keeps a 32-bit count of seconds. The count goes up by one on each pulse of a one-second tick input while the run bit is set. Software loads a new count in stages. It writes the three upper bytes into holding registers, and the write of the lowest byte moves all four bytes into the counter in one edge. Software reads the live count one byte at a time. Because of this, software that reads across a carry can see a torn value. It detects the case by reading the low byte again and seeing that it has gone down.

A 32-bit alarm value sits in four read-write byte registers. When the alarm is enabled and a tick moves the count onto the alarm value, a sticky status flag is set. The interrupt output is the status flag ANDed with the alarm enable. Software clears the status by writing a zero to the status bit in a separate status register.

Address map, 4-bit address. The two upper address bits select a group and the two lower bits select a byte within it:

| Address | Group | Contents |
|---|---|---|
| 0x0 | control | run control |
| 0x1 | control | alarm configuration |
| 0x2 | control | alarm status |
| 0x3 | control | unmapped |
| 0x4–0x7 | staging | write-only, reads as zero |
| 0x8–0xB | count | live count, read-only |
| 0xC–0xF | alarm | alarm value, read-write |

Within each 4-byte group, the byte at the lowest address is the least significant.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After synchronous reset, the count, staging bytes, alarm bytes, run bit, alarm enable and alarm status are all zero. Every address reads 0x00 and `alarm_irq` is low.
- R2: Bit 7 of address 0x0 is the run bit and reads back in bit 7. While it is 0, ticks leave the count unchanged.
- R3: While the run bit is 1, each cycle with `sec_tick` high adds one to the count. 0xFFFFFFFF wraps to 0x00000000.
- R4: A write to 0x5, 0x6 or 0x7 stores count byte 1, 2 or 3 in staging and does not change the count. A write to 0x4 loads {byte3, byte2, byte1, written data} into the count at that edge. A load in the same cycle as a tick takes priority over the increment.
- R5: Addresses 0x8 to 0xB return count bytes 0 to 3, little-endian, with 0x8 the least significant.
- R6: Addresses 0xC to 0xF hold alarm bytes 0 to 3, little-endian and readable back. Bit 7 of 0x1 is the alarm enable and reads back in bit 7.
- R7: When the alarm is enabled and a tick advances the count to equal the alarm value, status bit 0 of 0x2 is set at that same edge. `alarm_irq` equals status AND enable.
- R8: The status bit stays set until a write to 0x2 with bit 0 at 0. A write with bit 0 at 1 has no effect. A set and a clear in the same cycle leave the status set.
- R9: Clearing the alarm enable masks `alarm_irq` but keeps the status bit. Setting the enable again raises `alarm_irq` again.
- R10: While the alarm is disabled, neither a tick onto the alarm value nor a rewrite of the alarm bytes to the current count sets the status.
- R11: Address 0x3 reads 0x00 and writes to it change nothing. The staging addresses 0x4 to 0x7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; combinational, zero when not reading |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
On every cycle, the assertions check that the count holds while stopped, that it increments by exactly one on an enabled tick, and that a low-byte write commits the staged value. They also check that the status flag stays set until a clearing write, and that it can never rise while the alarm is disabled.

The following are shown only by the directed scenarios:
- the register encodings and the byte order;
- the wrap from all ones;
- the priority of a load over a tick;
- interrupt masking and unmasking;
- a set winning over a clear in the same cycle;
- the behaviour of the unmapped and write-only addresses.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 4;
    localparam int CNT_W   = BYTE_W * N_BYTES;
    localparam int IDX_W   = $clog2(N_BYTES);
    localparam int ADDR_W  = IDX_W + 2;
    localparam int EN_BIT  = 7;
    localparam int ST_BIT  = 0;

    typedef enum logic [1:0] {
        GRP_CONTROL = 2'd0,
        GRP_STAGE   = 2'd1,
        GRP_COUNT   = 2'd2,
        GRP_ALARM   = 2'd3
    } reg_group_e;

    localparam logic [IDX_W-1:0] IDX_RUN      = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_ALM_CFG  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_ALM_STAT = IDX_W'(2);

    typedef struct packed {
        logic               run_wr;
        logic               alm_cfg_wr;
        logic               alm_stat_wr;
        logic [N_BYTES-1:0] stage_wr;
        logic [N_BYTES-1:0] alarm_wr;
    } wr_strobe_t;

    function automatic logic [BYTE_W-1:0] byte_of(input logic [CNT_W-1:0] v,
                                                  input logic [IDX_W-1:0] i);
        return v[int'(i) * BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
    import rtc_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              run_en,
    input  logic              alm_en,
    input  logic              alm_status,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  alarm_val,
    output wr_strobe_t        strobe,
    output logic [BYTE_W-1:0] rdata
);
    reg_group_e       grp;
    logic [IDX_W-1:0] idx;
    logic             wr_acc;
    logic             rd_acc;

    assign grp    = reg_group_e'(bus_addr[ADDR_W-1 -: 2]);
    assign idx    = bus_addr[IDX_W-1:0];
    assign wr_acc = bus_sel & bus_we;
    assign rd_acc = bus_sel & ~bus_we;

    // Write strobes: at most one register per access
    always_comb begin
        strobe = '0;
        if (wr_acc) begin
            case (grp)
                GRP_CONTROL: begin
                    strobe.run_wr      = (idx == IDX_RUN);
                    strobe.alm_cfg_wr  = (idx == IDX_ALM_CFG);
                    strobe.alm_stat_wr = (idx == IDX_ALM_STAT);
                end
                GRP_STAGE: strobe.stage_wr[idx] = 1'b1;
                GRP_ALARM: strobe.alarm_wr[idx] = 1'b1;
                default:   ;
            endcase
        end
    end

    // Read mux; staging and unmapped slots return zero
    always_comb begin
        rdata = '0;
        if (rd_acc) begin
            case (grp)
                GRP_CONTROL: begin
                    if (idx == IDX_RUN)      rdata[EN_BIT] = run_en;
                    if (idx == IDX_ALM_CFG)  rdata[EN_BIT] = alm_en;
                    if (idx == IDX_ALM_STAT) rdata[ST_BIT] = alm_status;
                end
                GRP_COUNT: rdata = byte_of(count, idx);
                GRP_ALARM: rdata = byte_of(alarm_val, idx);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run_wr,
    input  logic [N_BYTES-1:0] stage_wr,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               sec_tick,
    output logic               run_en,
    output logic [CNT_W-1:0]   count,
    output logic               advance,
    output logic [CNT_W-1:0]   count_next
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] staged;
    logic             run_q;
    logic             load;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= 1'b0;
        else if (run_wr) run_q <= wdata[EN_BIT];
    end

    // Holding registers for the upper bytes; byte 0 arrives with the commit
    generate
        for (genvar b = 1; b < N_BYTES; b++) begin : g_stage
            logic [BYTE_W-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst)              stage_q <= '0;
                else if (stage_wr[b]) stage_q <= wdata;
            end
            assign staged[b*BYTE_W +: BYTE_W] = stage_q;
        end
    endgenerate
    assign staged[BYTE_W-1:0] = wdata;

    assign load       = stage_wr[0];
    assign advance    = run_q & sec_tick & ~load;
    assign count_next = count_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)          count_q <= '0;
        else if (load)    count_q <= staged;
        else if (advance) count_q <= count_next;
    end

    assign run_en = run_q;
    assign count  = count_q;

    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !load) |=> $stable(count_q))
        else $error("count moved while stopped");

    p_tick_step_r3: assert property (@(posedge clk) disable iff (rst)
        (run_q && sec_tick && !load) |=> (count_q == $past(count_q) + CNT_W'(1)))
        else $error("tick did not add one");

    p_load_commit_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (count_q == $past(staged)))
        else $error("low byte write did not commit staged value");
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               alm_cfg_wr,
    input  logic               alm_stat_wr,
    input  logic [N_BYTES-1:0] alarm_wr,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               advance,
    input  logic [CNT_W-1:0]   count_next,
    output logic               alm_en,
    output logic               alm_status,
    output logic [CNT_W-1:0]   alarm_val,
    output logic               irq
);
    logic en_q;
    logic status_q;
    logic hit;
    logic clear_req;

    always_ff @(posedge clk) begin
        if (rst)             en_q <= 1'b0;
        else if (alm_cfg_wr) en_q <= wdata[EN_BIT];
    end

    generate
        for (genvar b = 0; b < N_BYTES; b++) begin : g_alarm_byte
            logic [BYTE_W-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)              byte_q <= '0;
                else if (alarm_wr[b]) byte_q <= wdata;
            end
            assign alarm_val[b*BYTE_W +: BYTE_W] = byte_q;
        end
    endgenerate

    // Compare against the value the count is about to take
    assign hit       = en_q & advance & (count_next == alarm_val);
    assign clear_req = alm_stat_wr & ~wdata[ST_BIT];

    always_ff @(posedge clk) begin
        if (rst)            status_q <= 1'b0;
        else if (hit)       status_q <= 1'b1;
        else if (clear_req) status_q <= 1'b0;
    end

    assign alm_en     = en_q;
    assign alm_status = status_q;
    assign irq        = status_q & en_q;

    p_status_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (status_q && !clear_req) |=> status_q)
        else $error("status dropped without a clear");

    p_no_set_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        (!status_q && !en_q) |=> !status_q)
        else $error("status set while alarm disabled");

    p_match_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (en_q && advance && (count_next == alarm_val)) |=> (status_q && irq == en_q))
        else $error("match did not raise status");
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    wr_strobe_t       strobe;
    logic             run_en;
    logic             alm_en;
    logic             alm_status;
    logic             advance;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_next;
    logic [CNT_W-1:0] alarm_val;

    rtc_bus_decode u_decode (
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .run_en     (run_en),
        .alm_en     (alm_en),
        .alm_status (alm_status),
        .count      (count),
        .alarm_val  (alarm_val),
        .strobe     (strobe),
        .rdata      (bus_rdata)
    );

    rtc_sec_counter u_counter (
        .clk        (clk),
        .rst        (rst),
        .run_wr     (strobe.run_wr),
        .stage_wr   (strobe.stage_wr),
        .wdata      (bus_wdata),
        .sec_tick   (sec_tick),
        .run_en     (run_en),
        .count      (count),
        .advance    (advance),
        .count_next (count_next)
    );

    rtc_alarm u_alarm (
        .clk         (clk),
        .rst         (rst),
        .alm_cfg_wr  (strobe.alm_cfg_wr),
        .alm_stat_wr (strobe.alm_stat_wr),
        .alarm_wr    (strobe.alarm_wr),
        .wdata       (bus_wdata),
        .advance     (advance),
        .count_next  (count_next),
        .alm_en      (alm_en),
        .alm_status  (alm_status),
        .alarm_val   (alarm_val),
        .irq         (alarm_irq)
    );
endmodule

// File: tb/test_rtc_seconds_alarm.sv
`timescale 1ns/1ps
module test_rtc_seconds_alarm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int vectors = 0;
    int miscompares = 0;

    localparam logic [3:0] A_RUN = 4'h0, A_ACFG = 4'h1, A_STAT = 4'h2, A_HOLE = 4'h3;
    localparam logic [3:0] A_STG = 4'h4, A_CNT = 4'h8, A_ALM = 4'hC;

    rtc_seconds_alarm i_rtc_seconds_alarm (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic with_tick);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = with_tick;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic rd_count(output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(A_CNT + 4'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic load_count(input logic [31:0] v, input logic with_tick);
        wr(A_STG + 4'd3, v[31:24], 1'b0);
        wr(A_STG + 4'd2, v[23:16], 1'b0);
        wr(A_STG + 4'd1, v[15:8], 1'b0);
        wr(A_STG, v[7:0], with_tick);
    endtask

    task automatic set_alarm(input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(A_ALM + 4'(i), v[i*8 +: 8], 1'b0);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R1", $sformatf("reset read addr %0d", a), {24'h0, d}, 32'h0);
        end
        check("R1", "reset irq", {31'h0, alarm_irq}, 32'h0);
    endtask

    task automatic t_run_gate;
        logic [31:0] v; logic [7:0] d;
        tick_n(3);
        rd_count(v);
        check("R2", "stopped count", v, 32'h0);
        wr(A_RUN, 8'h80, 1'b0);
        rd(A_RUN, d);
        check("R2", "run bit readback", {24'h0, d}, 32'h80);
        tick_n(5);
        rd_count(v);
        check("R3", "five ticks", v, 32'd5);
        rd(A_CNT, d);
        check("R5", "count byte0", {24'h0, d}, 32'h05);
        rd(A_CNT + 4'd1, d);
        check("R5", "count byte1", {24'h0, d}, 32'h00);
    endtask

    task automatic t_staged_load;
        logic [31:0] v; logic [7:0] d;
        wr(A_RUN, 8'h00, 1'b0);
        wr(A_STG + 4'd3, 8'h12, 1'b0);
        wr(A_STG + 4'd2, 8'h34, 1'b0);
        wr(A_STG + 4'd1, 8'h56, 1'b0);
        rd_count(v);
        check("R4", "staging leaves count", v, 32'd5);
        wr(A_STG, 8'h78, 1'b0);
        rd_count(v);
        check("R4", "commit on low byte", v, 32'h12345678);
        rd(A_CNT, d);
        check("R5", "low byte at lowest addr", {24'h0, d}, 32'h78);
        rd(A_CNT + 4'd3, d);
        check("R5", "high byte at top addr", {24'h0, d}, 32'h12);
        wr(A_RUN, 8'h80, 1'b0);
        load_count(32'hAABBCCDD, 1'b1);
        rd_count(v);
        check("R4", "load wins over tick", v, 32'hAABBCCDD);
        tick_n(1);
        rd_count(v);
        check("R3", "tick after load", v, 32'hAABBCCDE);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(A_RUN, 8'h00, 1'b0);
        load_count(32'hFFFFFFFF, 1'b0);
        wr(A_RUN, 8'h80, 1'b0);
        tick_n(1);
        rd_count(v);
        check("R3", "wrap to zero", v, 32'h0);
    endtask

    task automatic t_alarm;
        logic [7:0] d;
        wr(A_RUN, 8'h00, 1'b0);
        load_count(32'h100, 1'b0);
        set_alarm(32'h102);
        rd(A_ALM, d);
        check("R6", "alarm byte0", {24'h0, d}, 32'h02);
        rd(A_ALM + 4'd1, d);
        check("R6", "alarm byte1", {24'h0, d}, 32'h01);
        wr(A_ACFG, 8'h80, 1'b0);
        rd(A_ACFG, d);
        check("R6", "alarm enable readback", {24'h0, d}, 32'h80);
        wr(A_RUN, 8'h80, 1'b0);
        tick_n(1);
        rd(A_STAT, d);
        check("R7", "no status before match", {24'h0, d}, 32'h0);
        check("R7", "no irq before match", {31'h0, alarm_irq}, 32'h0);
        tick_n(1);
        rd(A_STAT, d);
        check("R7", "status on match", {24'h0, d}, 32'h01);
        check("R7", "irq on match", {31'h0, alarm_irq}, 32'h1);
        tick_n(1);
        rd(A_STAT, d);
        check("R8", "status sticky past match", {24'h0, d}, 32'h01);
        wr(A_STAT, 8'h01, 1'b0);
        rd(A_STAT, d);
        check("R8", "writing one keeps status", {24'h0, d}, 32'h01);
        wr(A_ACFG, 8'h00, 1'b0);
        check("R9", "irq masked", {31'h0, alarm_irq}, 32'h0);
        rd(A_STAT, d);
        check("R9", "status kept when masked", {24'h0, d}, 32'h01);
        wr(A_ACFG, 8'h80, 1'b0);
        check("R9", "irq back on re-enable", {31'h0, alarm_irq}, 32'h1);
        wr(A_STAT, 8'h00, 1'b0);
        rd(A_STAT, d);
        check("R8", "status cleared", {24'h0, d}, 32'h0);
        check("R8", "irq low after clear", {31'h0, alarm_irq}, 32'h0);
        wr(A_RUN, 8'h00, 1'b0);
        load_count(32'h2FF, 1'b0);
        set_alarm(32'h300);
        wr(A_RUN, 8'h80, 1'b0);
        wr(A_STAT, 8'h00, 1'b1);
        rd(A_STAT, d);
        check("R8", "set wins over clear", {24'h0, d}, 32'h01);
        wr(A_STAT, 8'h00, 1'b0);
    endtask

    task automatic t_disabled;
        logic [31:0] v; logic [7:0] d;
        wr(A_ACFG, 8'h00, 1'b0);
        wr(A_RUN, 8'h00, 1'b0);
        load_count(32'h200, 1'b0);
        set_alarm(32'h201);
        wr(A_RUN, 8'h80, 1'b0);
        tick_n(1);
        rd_count(v);
        check("R10", "count reached alarm value", v, 32'h201);
        rd(A_STAT, d);
        check("R10", "no status while disabled", {24'h0, d}, 32'h0);
        check("R10", "no irq while disabled", {31'h0, alarm_irq}, 32'h0);
        set_alarm(32'h201);
        rd(A_STAT, d);
        check("R10", "rewrite alarm no status", {24'h0, d}, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        wr(A_HOLE, 8'hFF, 1'b0);
        rd(A_HOLE, d);
        check("R11", "hole reads zero", {24'h0, d}, 32'h0);
        rd(A_RUN, d);
        check("R11", "run unchanged by hole write", {24'h0, d}, 32'h80);
        rd(A_ACFG, d);
        check("R11", "alarm cfg unchanged by hole write", {24'h0, d}, 32'h0);
        rd(A_STAT, d);
        check("R11", "status unchanged by hole write", {24'h0, d}, 32'h0);
        rd(A_STG + 4'd2, d);
        check("R11", "staging reads zero", {24'h0, d}, 32'h0);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_run_gate();
        t_staged_load();
        t_wrap();
        t_alarm();
        t_disabled();
        t_unmapped();
        report();
    end

    initial begin
        #1000000;
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule